// File: doc/BRIEF.md
# Dimension-Ordered Wormhole Mesh Router

This block is the packet switch for one tile of a two-dimensional mesh. It has five word-wide stream ports: four towards the neighbouring tiles (north, east, south, west) and one towards the tile's own processor. It carries traffic whose pattern cannot be known ahead of time, such as cache-miss refills, I/O transfers and interrupt messages. Every packet opens with a header word. The header carries the destination tile coordinates and the number of payload words that follow.

A packet travels along X until its column matches the tile's own coordinate, then along Y, and is finally ejected at the local port. Switching is wormhole: the first word that wins an output claims it, and the payload follows through the same path. No other input may enter that output until the packet's last word has gone. Inputs that compete for a free output are served in round-robin order.

Each input queues arriving words in a small FIFO, and each output holds one word in a register, so a word crosses the tile in two register stages. A header that changes axis (from the X lines onto the Y lines, or the reverse) pays one extra cycle before it may bid for its output. Every port is valid/ready. A word moves only in a cycle where both valid and ready are high at the clock edge. An output that sees ready low keeps its word and data unchanged. An input drops ready while its queue is full, and no word is ever dropped. The tile's own coordinates are plain inputs, held steady during operation.

Top module: `mesh_router`

## Requirements
- R1: After reset every output valid is low and every input ready is high.
- R2: A header holds destination X in bits [31:28] and destination Y in bits [27:24]. Port indices are north 0, east 1, south 2, west 3, local 4. If destination X is greater than the tile X the packet leaves on east (1). If it is smaller, the packet leaves on west (3).
- R3: If destination X equals the tile X, the Y coordinate decides. Greater leaves on north (0), smaller on south (2), and equal leaves on local (4).
- R4: Header bits [4:0] give the payload length L (0 to 31). The chosen output forwards exactly L+1 words, header first, each unchanged and in arrival order, and no other output carries any of them.
- R5: For a packet that does not turn, the header is accepted at one clock edge and becomes valid at the output at the next edge.
- R6: A turn is a header entering on east or west (1, 3) that leaves on north or south (0, 2), or one entering on north or south that leaves on east or west. A turn adds exactly one cycle to the latency of R5. Ejection to local is not a turn.
- R7: Once an output has taken a header, it carries only words from that input until L+1 words have passed.
- R8: When two inputs keep requesting the same output, the output grants them in alternation, one whole packet each.
- R9: While an output's ready is low, its valid and data hold steady. An input accepts at most 4 queued words plus those that have moved on, then holds ready low. After the stall, every word arrives in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| my_x | input | 4 | X coordinate of this tile |
| my_y | input | 4 | Y coordinate of this tile |
| in_valid | input | 5 | Per-input word valid, bit index = port index |
| in_data | input | 160 | Per-input word, port p in bits [32p+31:32p] |
| in_ready | output | 5 | Per-input ready, low while that input's queue is full |
| out_valid | output | 5 | Per-output word valid |
| out_data | output | 160 | Per-output word, port p in bits [32p+31:32p] |
| out_ready | input | 5 | Per-output ready from the neighbour |

## Verification
The bench measures header latency on straight paths and on turning paths. A router that forgot the turn cycle, or charged it on ejection, shows a latency off by one. Zero-length and maximum-length (31) packets probe the lock release. An off-by-one in the remaining-word count would let a packet lose its tail, or hold the output and starve the next packet. Two inputs streaming packets into one output expose interleaving (a payload word from the other source inside a packet) and an unfair arbiter (the same source served twice in a row). A blocked output checks that ready drops after exactly five accepted words and that the held word does not change.

// File: rtl/router_pkg.sv
package router_pkg;

  localparam int NPORTS = 5;

  typedef enum logic [2:0] {
    P_NORTH = 3'd0,
    P_EAST  = 3'd1,
    P_SOUTH = 3'd2,
    P_WEST  = 3'd3,
    P_LOCAL = 3'd4
  } port_e;

  // A header changes axis when it moves between the X lines and the Y lines.
  function automatic logic is_turn(input int src, input int dst);
    logic src_x, src_y, dst_x, dst_y;
    src_x = (src == int'(P_EAST))  || (src == int'(P_WEST));
    src_y = (src == int'(P_NORTH)) || (src == int'(P_SOUTH));
    dst_x = (dst == int'(P_EAST))  || (dst == int'(P_WEST));
    dst_y = (dst == int'(P_NORTH)) || (dst == int'(P_SOUTH));
    return (src_x && dst_y) || (src_y && dst_x);
  endfunction

endpackage

// File: rtl/router_fifo.sv
module router_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_ready,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  input  logic             rd_pop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             do_wr, do_rd;

  assign wr_ready = (count != CW'(DEPTH));
  assign rd_valid = (count != '0);
  assign rd_data  = mem[rd_ptr];
  assign do_wr    = wr_valid && wr_ready;
  assign do_rd    = rd_pop && rd_valid;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/router_rr_arb.sv
module router_rr_arb #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         take,
  output logic [N-1:0] gnt
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr_q;
  logic [IW-1:0] win;
  logic          found;

  always_comb begin
    gnt   = '0;
    win   = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % N;
      if (!found && req[idx]) begin
        found    = 1'b1;
        gnt[idx] = 1'b1;
        win      = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (take && found) begin
      ptr_q <= (win == IW'(N - 1)) ? '0 : win + 1'b1;
    end
  end
endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import router_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int COORD_W    = 4,
  parameter int LEN_W      = 5,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [COORD_W-1:0]       my_x,
  input  logic [COORD_W-1:0]       my_y,
  input  logic [NPORTS-1:0]        in_valid,
  input  logic [NPORTS*DATA_W-1:0] in_data,
  output logic [NPORTS-1:0]        in_ready,
  output logic [NPORTS-1:0]        out_valid,
  output logic [NPORTS*DATA_W-1:0] out_data,
  input  logic [NPORTS-1:0]        out_ready
);
  localparam int NP  = NPORTS;
  localparam int PW  = $clog2(NP);
  localparam int XHI = DATA_W - 1;
  localparam int YHI = DATA_W - 1 - COORD_W;

  logic [NP-1:0]              hd_valid, pop, bound, turn, turn_ok_q, want;
  logic [DATA_W-1:0]          hd_data [NP];
  logic [PW-1:0]              dest    [NP];
  logic [NP-1:0][NP-1:0]      req_m, gnt_raw, gnt_m;   // [output][input]
  logic [NP-1:0]              lock_q, ov_q, can_load, mv;
  logic [PW-1:0]              owner_q [NP];
  logic [PW-1:0]              src     [NP];
  logic [PW-1:0]              win     [NP];
  logic [NP-1:0][LEN_W-1:0]   rem_q;
  logic [DATA_W-1:0]          od_q    [NP];

  // Stage one: one queue per input, and stage two: one register per output.
  for (genvar i = 0; i < NP; i++) begin : g_in
    router_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (in_valid[i]),
      .wr_data  (in_data[i*DATA_W +: DATA_W]),
      .wr_ready (in_ready[i]),
      .rd_valid (hd_valid[i]),
      .rd_data  (hd_data[i]),
      .rd_pop   (pop[i])
    );
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    assign out_valid[o]                  = ov_q[o];
    assign out_data[o*DATA_W +: DATA_W]  = od_q[o];
    assign can_load[o]                   = !ov_q[o] || out_ready[o];

    router_rr_arb #(.N(NP)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_m[o]),
      .take  (can_load[o] && !lock_q[o]),
      .gnt   (gnt_raw[o])
    );
  end

  // X first, then Y, then eject.
  always_comb begin
    for (int i = 0; i < NP; i++) begin
      logic [COORD_W-1:0] hx, hy;
      hx = hd_data[i][XHI -: COORD_W];
      hy = hd_data[i][YHI -: COORD_W];
      if (hx > my_x)      dest[i] = PW'(P_EAST);
      else if (hx < my_x) dest[i] = PW'(P_WEST);
      else if (hy > my_y) dest[i] = PW'(P_NORTH);
      else if (hy < my_y) dest[i] = PW'(P_SOUTH);
      else                dest[i] = PW'(P_LOCAL);
      turn[i] = is_turn(i, int'(dest[i]));
    end
  end

  // An input is bound while some output is locked to it; its head is then payload.
  always_comb begin
    bound = '0;
    for (int o = 0; o < NP; o++) begin
      if (lock_q[o]) bound[owner_q[o]] = 1'b1;
    end
    for (int i = 0; i < NP; i++) begin
      want[i] = hd_valid[i] && !bound[i] && (!turn[i] || turn_ok_q[i]);
    end
    for (int o = 0; o < NP; o++) begin
      for (int i = 0; i < NP; i++) begin
        req_m[o][i] = want[i] && (dest[i] == PW'(o));
      end
    end
  end

  // Crossbar select: a locked output follows its owner, a free one its winner.
  always_comb begin
    pop = '0;
    for (int o = 0; o < NP; o++) begin
      gnt_m[o] = (can_load[o] && !lock_q[o]) ? gnt_raw[o] : '0;
      win[o]   = '0;
      for (int i = 0; i < NP; i++) begin
        if (gnt_raw[o][i]) win[o] = PW'(i);
      end
      if (lock_q[o]) begin
        src[o] = owner_q[o];
        mv[o]  = hd_valid[owner_q[o]] && can_load[o];
      end else begin
        src[o] = win[o];
        mv[o]  = |gnt_m[o];
      end
      if (mv[o]) pop[src[o]] = 1'b1;
    end
  end

  // One-cycle hold on a header that changes axis.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      turn_ok_q <= '0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (pop[i] && !bound[i])
          turn_ok_q[i] <= 1'b0;
        else if (hd_valid[i] && !bound[i] && turn[i])
          turn_ok_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int o = 0; o < NP; o++) begin
        ov_q[o]    <= 1'b0;
        od_q[o]    <= '0;
        lock_q[o]  <= 1'b0;
        owner_q[o] <= '0;
        rem_q[o]   <= '0;
      end
    end else begin
      for (int o = 0; o < NP; o++) begin
        if (mv[o]) begin
          ov_q[o] <= 1'b1;
          od_q[o] <= hd_data[src[o]];
        end else if (out_ready[o]) begin
          ov_q[o] <= 1'b0;
        end
        if (!lock_q[o] && |gnt_m[o]) begin
          if (hd_data[win[o]][LEN_W-1:0] != '0) begin
            lock_q[o]  <= 1'b1;
            owner_q[o] <= win[o];
            rem_q[o]   <= hd_data[win[o]][LEN_W-1:0];
          end
        end else if (lock_q[o] && mv[o]) begin
          rem_q[o] <= rem_q[o] - 1'b1;
          if (rem_q[o] == LEN_W'(1)) lock_q[o] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mesh_router_chk.sv
module mesh_router_chk #(
  parameter int NP    = 5,
  parameter int DW    = 32,
  parameter int LEN_W = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NP-1:0]         out_valid,
  input logic [NP-1:0]         out_ready,
  input logic [NP*DW-1:0]      out_data,
  input logic [NP-1:0][NP-1:0] gnt_m,
  input logic [NP-1:0]         lock_q,
  input logic [NP-1:0][LEN_W-1:0] rem_q
);
  for (genvar o = 0; o < NP; o++) begin : g_port
    // R9: a stalled output keeps its word.
    p_hold_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] && !out_ready[o] |=> out_valid[o]);

    p_hold_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] && !out_ready[o] |=> $stable(out_data[o*DW +: DW]));

    // R8: a free output grants at most one input per cycle.
    p_one_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_m[o]));

    // R7: a locked output with words still owed stays locked.
    p_lock_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[o] && (rem_q[o] > LEN_W'(1)) |=> lock_q[o]);

    // R7: a locked output issues no fresh grant.
    p_no_grant_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[o] |-> (gnt_m[o] == '0));
  end
endmodule

bind mesh_router mesh_router_chk #(.NP(NPORTS), .DW(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .gnt_m     (gnt_m),
  .lock_q    (lock_q),
  .rem_q     (rem_q)
);

// File: tb/mesh_router_tb.sv
`timescale 1ns/100ps
module mesh_router_tb;
  localparam int NP = 5;
  localparam int DW = 32;
  localparam int WD = 50000;

  // Vector table: input port, dest x, dest y, length, expected output, expected latency.
  localparam int NV = 8;
  localparam int V_IN  [NV] = '{4, 4, 3, 0, 1, 2, 4, 1};
  localparam int V_DX  [NV] = '{4, 0, 2, 2, 2, 3, 2, 0};
  localparam int V_DY  [NV] = '{2, 2, 5, 0, 2, 4, 2, 2};
  localparam int V_LEN [NV] = '{3, 0, 2, 1, 4, 1, 0, 31};
  localparam int V_OUT [NV] = '{1, 3, 0, 2, 4, 1, 4, 3};
  localparam int V_LAT [NV] = '{1, 1, 2, 1, 1, 2, 1, 1};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [3:0]        my_x = 4'd2, my_y = 4'd2;
  logic [NP-1:0]     in_valid = '0;
  logic [NP*DW-1:0]  in_data = '0;
  logic [NP-1:0]     in_ready;
  logic [NP-1:0]     out_valid;
  logic [NP*DW-1:0]  out_data;
  logic [NP-1:0]     out_ready = '1;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit done = 0;
  logic [DW-1:0] cap_data [NP][64];
  int cap_n [NP];
  int first_cyc [NP];
  int t_in [NP];

  mesh_router u_dut (
    .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (rst_n && out_valid[p] && out_ready[p]) begin
        if (cap_n[p] == 0) first_cyc[p] = cyc;
        if (cap_n[p] < 64) cap_data[p][cap_n[p]] = out_data[p*DW +: DW];
        cap_n[p]++;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_of(int p, int dx, int dy, int len, int tag, int k);
    if (k == 0) return {4'(dx), 4'(dy), 19'd0, 5'(len)};
    return {8'hA5, 8'(p), 8'(tag), 8'(k)};
  endfunction

  task automatic clear_caps();
    for (int p = 0; p < NP; p++) begin
      cap_n[p] = 0; first_cyc[p] = -1; t_in[p] = -1;
    end
  endtask

  task automatic send_pkt(int p, int dx, int dy, int len, int tag);
    for (int k = 0; k <= len; k++) begin
      @(posedge clk); #1;
      in_valid[p] = 1'b1;
      in_data[p*DW +: DW] = word_of(p, dx, dy, len, tag, k);
      @(negedge clk);
      while (!in_ready[p]) @(negedge clk);
      if (k == 0) t_in[p] = cyc + 1;
    end
    @(posedge clk); #1;
    in_valid[p] = 1'b0;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    clear_caps();
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid after reset", 64'(out_valid), 64'h0);
    chk("R1", "in_ready after reset", 64'(in_ready), 64'h1F);

    // Table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      int others;
      clear_caps();
      send_pkt(V_IN[v], V_DX[v], V_DY[v], V_LEN[v], v);
      repeat (8) @(posedge clk);
      @(negedge clk);
      chk("R2/R3", $sformatf("vec %0d word count on port %0d", v, V_OUT[v]),
          64'(cap_n[V_OUT[v]]), 64'(V_LEN[v] + 1));
      for (int k = 0; k <= V_LEN[v] && k < cap_n[V_OUT[v]]; k++)
        chk("R4", $sformatf("vec %0d word %0d", v, k), 64'(cap_data[V_OUT[v]][k]),
            64'(word_of(V_IN[v], V_DX[v], V_DY[v], V_LEN[v], v, k)));
      others = 0;
      for (int p = 0; p < NP; p++) if (p != V_OUT[v]) others += cap_n[p];
      chk("R4", $sformatf("vec %0d words on other ports", v), 64'(others), 64'h0);
      chk(V_LAT[v] == 2 ? "R6" : "R5", $sformatf("vec %0d header latency", v),
          64'(first_cyc[V_OUT[v]] - t_in[V_IN[v]]), 64'(V_LAT[v]));
    end

    // R7 R8: two inputs stream two packets each into the east output.
    clear_caps();
    fork
      begin send_pkt(3, 4, 2, 2, 1); send_pkt(3, 4, 2, 2, 2); end
      begin send_pkt(4, 4, 2, 2, 3); send_pkt(4, 4, 2, 2, 4); end
    join
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R7", "contention total words", 64'(cap_n[1]), 64'd12);
    for (int g = 0; g < 4; g++) begin
      chk("R7", $sformatf("group %0d header", g), 64'(cap_data[1][3*g]), 64'h42000002);
      chk("R7", $sformatf("group %0d payload source", g),
          64'(cap_data[1][3*g+1][23:16]), 64'(cap_data[1][3*g+2][23:16]));
      if (g > 0)
        chk("R8", $sformatf("group %0d alternates source", g),
            64'(cap_data[1][3*g+1][23:16] != cap_data[1][3*g-2][23:16]), 64'h1);
    end

    // R9: back-pressure on the east output.
    clear_caps();
    @(posedge clk); #1 out_ready[1] = 1'b0;
    fork
      send_pkt(4, 4, 2, 6, 9);
    join_none
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk("R9", "input ready while blocked", 64'(in_ready[4]), 64'h0);
    chk("R9", "words leaked while blocked", 64'(cap_n[1]), 64'h0);
    chk("R9", "held valid", 64'(out_valid[1]), 64'h1);
    chk("R9", "held data", 64'(out_data[DW +: DW]), 64'(word_of(4, 4, 2, 6, 9, 0)));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", "held data later", 64'(out_data[DW +: DW]), 64'(word_of(4, 4, 2, 6, 9, 0)));
    @(posedge clk); #1 out_ready[1] = 1'b1;
    wait fork;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R9", "words after stall", 64'(cap_n[1]), 64'd7);
    for (int k = 0; k < 7 && k < cap_n[1]; k++)
      chk("R9", $sformatf("order after stall word %0d", k), 64'(cap_data[1][k]),
          64'(word_of(4, 4, 2, 6, 9, k)));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule